// File: doc/BRIEF.md
# Sharer Removal Engine for a Linked-List Directory

This block handles cleanup messages, which a private cache sends when it drops its copy of a line. Each message carries the line number, the sender's id, the cache way and a flag that tells an instruction copy from a data copy. The directory entry for the line is supplied with the message as a snapshot: an owner slot (id and flag), a sharer count and a pointer into a shared heap. When the count is two or more, the sharers after the owner sit in a singly linked list in the heap. The last element of that list points to itself.

Once the heap lock is granted, the engine finds the sharer in one of three places and unlinks it: the owner slot, the head of the list, or an element deeper in the list. It writes back the updated directory fields, and the heap entry it freed becomes the new head of the free list. After that it looks for the line in an internal table of pending invalidations. If it finds the entry, it decrements that entry's response count. When the count reaches zero, it clears the entry, signals the configuration side if that side opened the entry, and sends a delayed write response if one was waiting. Every cleanup ends with an acknowledgement. The heap load port and the table open port belong to the allocating agents. Directory storage is outside this block.

Top module: `sharer_cleanup_engine`

## Requirements
- R1: A cleanup is taken when `req_valid` is high while `req_ready` is high. `req_ready` stays low from that point until the cycle after the acknowledgement.
- R2: A sharer matches the cleanup only when both its id and its instruction/data flag are equal to those of the message.
- R3: On a match in the owner slot, the count drops by one. If the heap list is not empty, its head entry is promoted into the owner slot and freed, and the pointer moves to the head's successor.
- R4: On a match at the list head, the owner slot stays unchanged, the head entry is freed, the pointer moves to the head's successor, and the count drops by one.
- R5: On a match deeper in the list, the predecessor is relinked to the successor of the removed entry. If the removed entry was the last one, the predecessor now points to itself. The pointer stays the same, the count drops by one, and the removed entry is freed.
- R6: When no sharer matches, `dir_wr` does not pulse and no heap entry is freed.
- R7: A freed entry becomes `free_head`, and `free_valid` goes high.
- R8: `heap_req` is high from acceptance until the heap work is finished. While the grant is low, neither the directory nor the heap is written. `dir_wr` pulses at most once per cleanup.
- R9: If the pending table has no valid entry for the line, neither `cfg_line_dec` nor `wr_rsp_valid` pulses, and no table state changes.
- R10: A matching table entry has its count decremented. When the count reaches zero, the entry is cleared, and `cfg_line_dec` pulses if the entry was opened by the configuration side.
- R11: When a cleared entry was waiting on a write, `wr_rsp_valid` pulses with the saved source, transaction and packet ids. The pulse comes in the cycle just before the acknowledgement.
- R12: Every cleanup ends with a one-cycle `ack_valid` carrying the line, the way and the source id of the message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Cleanup message present |
| req_ready | output | 1 | Engine idle, message accepted |
| req_line | input | LINE_W | Line number |
| req_id | input | ID_W | Sender id |
| req_inst | input | 1 | 1 = instruction copy |
| req_way | input | WAY_W | Way of the dropped copy |
| snap_own_id | input | ID_W | Directory owner id |
| snap_own_inst | input | 1 | Directory owner flag |
| snap_cnt | input | CNT_W | Directory sharer count |
| snap_ptr | input | HP_W | Heap list head index |
| heap_req | output | 1 | Heap lock request |
| heap_grant | input | 1 | Heap lock granted, held while requested |
| dir_wr | output | 1 | Directory update pulse |
| dir_wr_line | output | LINE_W | Line to update |
| dir_wr_own_id | output | ID_W | New owner id |
| dir_wr_own_inst | output | 1 | New owner flag |
| dir_wr_ptr | output | HP_W | New list head |
| dir_wr_cnt | output | CNT_W | New sharer count |
| free_head | output | HP_W | Head of the free list |
| free_valid | output | 1 | Free list not empty |
| hp_ld | input | 1 | Heap entry load |
| hp_ld_idx | input | HP_W | Entry to load |
| hp_ld_id | input | ID_W | Sharer id |
| hp_ld_inst | input | 1 | Sharer flag |
| hp_ld_next | input | HP_W | Successor index |
| tb_open | input | 1 | Open a pending-table entry |
| tb_open_idx | input | TB_W | Slot to open |
| tb_open_line | input | LINE_W | Line awaited |
| tb_open_cnt | input | CNT_W | Responses awaited (at least 1) |
| tb_open_cfg | input | 1 | Opened by the configuration side |
| tb_open_wwait | input | 1 | A write waits on this entry |
| tb_open_src | input | ID_W | Saved write source id |
| tb_open_trd | input | TRD_W | Saved write transaction id |
| tb_open_pkt | input | PKT_W | Saved write packet id |
| cfg_line_dec | output | 1 | One configuration line finished |
| wr_rsp_valid | output | 1 | Delayed write response |
| wr_rsp_src | output | ID_W | Response source id |
| wr_rsp_trd | output | TRD_W | Response transaction id |
| wr_rsp_pkt | output | PKT_W | Response packet id |
| ack_valid | output | 1 | Cleanup acknowledgement |
| ack_line | output | LINE_W | Acknowledged line |
| ack_way | output | WAY_W | Acknowledged way |
| ack_id | output | ID_W | Acknowledged source id |

## Verification
A broken link in the heap does not show up at the cleanup that writes it. It appears later, when a cleanup for a sharer further down the same list finds no match: `dir_wr` stays silent and `free_head` does not move, one or more cleanups after the faulty unlink. A wrong table count appears as a `cfg_line_dec` or a write response that comes one cleanup early or late. A wrong owner promotion appears directly on the `dir_wr` fields of the same cleanup.

// File: rtl/sre_pkg.sv
package sre_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_REQ, S_LOCK, S_SEARCH, S_COMMIT, S_FREE, S_TBL, S_WRSP, S_ACK
  } sre_state_e;
endpackage

// File: rtl/sre_heap.sv
module sre_heap #(
  parameter int ID_W = 4,
  parameter int HP_N = 8,
  localparam int HP_W = $clog2(HP_N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  input  logic [HP_W-1:0] ld_idx,
  input  logic [ID_W-1:0] ld_id,
  input  logic            ld_inst,
  input  logic [HP_W-1:0] ld_next,
  input  logic            nx_en,
  input  logic [HP_W-1:0] nx_idx,
  input  logic [HP_W-1:0] nx_next,
  input  logic [HP_W-1:0] rd_idx,
  output logic [ID_W-1:0] rd_id,
  output logic            rd_inst,
  output logic [HP_W-1:0] rd_next
);
  logic [ID_W-1:0] h_id   [HP_N];
  logic            h_inst [HP_N];
  logic [HP_W-1:0] h_next [HP_N];

  always_ff @(posedge clk) begin
    for (int i = 0; i < HP_N; i++) begin
      if (!rst_n) begin
        h_id[i]   <= '0;
        h_inst[i] <= 1'b0;
        h_next[i] <= HP_W'(i);
      end else begin
        if (ld_en && ld_idx == HP_W'(i)) begin
          h_id[i]   <= ld_id;
          h_inst[i] <= ld_inst;
          h_next[i] <= ld_next;
        end
        // engine-side link writes take priority over the allocator load
        if (nx_en && nx_idx == HP_W'(i)) h_next[i] <= nx_next;
      end
    end
  end

  assign rd_id   = h_id[rd_idx];
  assign rd_inst = h_inst[rd_idx];
  assign rd_next = h_next[rd_idx];
endmodule

// File: rtl/sre_ptable.sv
module sre_ptable #(
  parameter int LINE_W = 8,
  parameter int CNT_W  = 4,
  parameter int TB_N   = 4,
  parameter int ID_W   = 4,
  parameter int TRD_W  = 3,
  parameter int PKT_W  = 4,
  localparam int TB_W  = $clog2(TB_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_en,
  input  logic [TB_W-1:0]   op_idx,
  input  logic [LINE_W-1:0] op_line,
  input  logic [CNT_W-1:0]  op_cnt,
  input  logic              op_cfg,
  input  logic              op_ww,
  input  logic [ID_W-1:0]   op_src,
  input  logic [TRD_W-1:0]  op_trd,
  input  logic [PKT_W-1:0]  op_pkt,
  input  logic [LINE_W-1:0] lk_line,
  input  logic              dec_en,
  output logic              hit,
  output logic              hit_last,
  output logic              hit_cfg,
  output logic              hit_ww,
  output logic [ID_W-1:0]   hit_src,
  output logic [TRD_W-1:0]  hit_trd,
  output logic [PKT_W-1:0]  hit_pkt
);
  logic              t_v   [TB_N];
  logic [LINE_W-1:0] t_line[TB_N];
  logic [CNT_W-1:0]  t_cnt [TB_N];
  logic              t_cfg [TB_N];
  logic              t_ww  [TB_N];
  logic [ID_W-1:0]   t_src [TB_N];
  logic [TRD_W-1:0]  t_trd [TB_N];
  logic [PKT_W-1:0]  t_pkt [TB_N];
  logic [TB_N-1:0]   match_vec;
  logic [TB_W-1:0]   hit_idx;

  for (genvar g = 0; g < TB_N; g++) begin : g_cmp
    assign match_vec[g] = t_v[g] && (t_line[g] == lk_line);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = TB_N - 1; i >= 0; i--)
      if (match_vec[i]) hit_idx = TB_W'(i);
  end

  assign hit      = |match_vec;
  assign hit_last = (t_cnt[hit_idx] == CNT_W'(1));
  assign hit_cfg  = t_cfg[hit_idx];
  assign hit_ww   = t_ww[hit_idx];
  assign hit_src  = t_src[hit_idx];
  assign hit_trd  = t_trd[hit_idx];
  assign hit_pkt  = t_pkt[hit_idx];

  always_ff @(posedge clk) begin
    for (int i = 0; i < TB_N; i++) begin
      if (!rst_n) begin
        t_v[i] <= 1'b0; t_line[i] <= '0; t_cnt[i] <= '0; t_cfg[i] <= 1'b0;
        t_ww[i] <= 1'b0; t_src[i] <= '0; t_trd[i] <= '0; t_pkt[i] <= '0;
      end else if (op_en && op_idx == TB_W'(i)) begin
        t_v[i] <= 1'b1; t_line[i] <= op_line; t_cnt[i] <= op_cnt; t_cfg[i] <= op_cfg;
        t_ww[i] <= op_ww; t_src[i] <= op_src; t_trd[i] <= op_trd; t_pkt[i] <= op_pkt;
      end else if (dec_en && hit && hit_idx == TB_W'(i)) begin
        t_cnt[i] <= t_cnt[i] - CNT_W'(1);
        if (t_cnt[i] == CNT_W'(1)) t_v[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sharer_cleanup_engine.sv
module sharer_cleanup_engine
  import sre_pkg::*;
#(
  parameter int LINE_W = 8,
  parameter int ID_W   = 4,
  parameter int WAY_W  = 2,
  parameter int CNT_W  = 4,
  parameter int HP_N   = 8,
  parameter int TB_N   = 4,
  parameter int TRD_W  = 3,
  parameter int PKT_W  = 4,
  localparam int HP_W  = $clog2(HP_N),
  localparam int TB_W  = $clog2(TB_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LINE_W-1:0] req_line,
  input  logic [ID_W-1:0]   req_id,
  input  logic              req_inst,
  input  logic [WAY_W-1:0]  req_way,
  input  logic [ID_W-1:0]   snap_own_id,
  input  logic              snap_own_inst,
  input  logic [CNT_W-1:0]  snap_cnt,
  input  logic [HP_W-1:0]   snap_ptr,
  output logic              heap_req,
  input  logic              heap_grant,
  output logic              dir_wr,
  output logic [LINE_W-1:0] dir_wr_line,
  output logic [ID_W-1:0]   dir_wr_own_id,
  output logic              dir_wr_own_inst,
  output logic [HP_W-1:0]   dir_wr_ptr,
  output logic [CNT_W-1:0]  dir_wr_cnt,
  output logic [HP_W-1:0]   free_head,
  output logic              free_valid,
  input  logic              hp_ld,
  input  logic [HP_W-1:0]   hp_ld_idx,
  input  logic [ID_W-1:0]   hp_ld_id,
  input  logic              hp_ld_inst,
  input  logic [HP_W-1:0]   hp_ld_next,
  input  logic              tb_open,
  input  logic [TB_W-1:0]   tb_open_idx,
  input  logic [LINE_W-1:0] tb_open_line,
  input  logic [CNT_W-1:0]  tb_open_cnt,
  input  logic              tb_open_cfg,
  input  logic              tb_open_wwait,
  input  logic [ID_W-1:0]   tb_open_src,
  input  logic [TRD_W-1:0]  tb_open_trd,
  input  logic [PKT_W-1:0]  tb_open_pkt,
  output logic              cfg_line_dec,
  output logic              wr_rsp_valid,
  output logic [ID_W-1:0]   wr_rsp_src,
  output logic [TRD_W-1:0]  wr_rsp_trd,
  output logic [PKT_W-1:0]  wr_rsp_pkt,
  output logic              ack_valid,
  output logic [LINE_W-1:0] ack_line,
  output logic [WAY_W-1:0]  ack_way,
  output logic [ID_W-1:0]   ack_id
);
  // a sharer matches only when id and copy flag agree
  function automatic logic f_same(input logic [ID_W-1:0] a_id, input logic a_inst,
                                  input logic [ID_W-1:0] b_id, input logic b_inst);
    return (a_id == b_id) && (a_inst == b_inst);
  endfunction

  // successor to store in the predecessor: itself when the removed entry ended the list
  function automatic logic [HP_W-1:0] f_relink(input logic [HP_W-1:0] prev,
                                               input logic [HP_W-1:0] cur,
                                               input logic [HP_W-1:0] nxt);
    return (nxt == cur) ? prev : nxt;
  endfunction

  sre_state_e st;
  logic [LINE_W-1:0] r_line;
  logic [ID_W-1:0]   r_id, r_own_id, r_nown_id;
  logic              r_inst, r_own_inst, r_nown_inst;
  logic [WAY_W-1:0]  r_way;
  logic [CNT_W-1:0]  r_cnt;
  logic [HP_W-1:0]   r_ptr, r_prev, r_cur, r_nptr, r_fix_idx, r_fix_next, r_free_idx;
  logic              r_found, r_fix, r_free_need;
  logic [ID_W-1:0]   r_w_src;
  logic [TRD_W-1:0]  r_w_trd;
  logic [PKT_W-1:0]  r_w_pkt;

  logic [HP_W-1:0] rd_idx, h_next, nx_idx, nx_next;
  logic [ID_W-1:0] h_id;
  logic            h_inst, h_last, h_hit, own_hit, multi, nx_en;
  logic            tb_hit, tb_last, tb_cfg, tb_ww, tb_dec;
  logic [ID_W-1:0] tb_src;
  logic [TRD_W-1:0] tb_trd;
  logic [PKT_W-1:0] tb_pkt;

  // named internal events for the checker
  logic lock_wait, heap_wr_evt;

  assign rd_idx  = (st == S_LOCK) ? r_ptr : r_cur;
  assign h_last  = (h_next == rd_idx);
  assign h_hit   = f_same(h_id, h_inst, r_id, r_inst);
  assign own_hit = (r_cnt != '0) && f_same(r_own_id, r_own_inst, r_id, r_inst);
  assign multi   = (r_cnt > CNT_W'(1));

  assign nx_en   = (st == S_COMMIT && r_fix) || (st == S_FREE);
  assign nx_idx  = (st == S_FREE) ? r_free_idx : r_fix_idx;
  assign nx_next = (st == S_FREE) ? (free_valid ? free_head : r_free_idx) : r_fix_next;
  assign tb_dec  = (st == S_TBL) && tb_hit;

  assign lock_wait   = (st == S_REQ);
  assign heap_wr_evt = nx_en;

  sre_heap #(.ID_W(ID_W), .HP_N(HP_N)) u_heap (
    .clk, .rst_n,
    .ld_en(hp_ld), .ld_idx(hp_ld_idx), .ld_id(hp_ld_id), .ld_inst(hp_ld_inst), .ld_next(hp_ld_next),
    .nx_en, .nx_idx, .nx_next,
    .rd_idx, .rd_id(h_id), .rd_inst(h_inst), .rd_next(h_next)
  );

  sre_ptable #(.LINE_W(LINE_W), .CNT_W(CNT_W), .TB_N(TB_N), .ID_W(ID_W),
               .TRD_W(TRD_W), .PKT_W(PKT_W)) u_tbl (
    .clk, .rst_n,
    .op_en(tb_open), .op_idx(tb_open_idx), .op_line(tb_open_line), .op_cnt(tb_open_cnt),
    .op_cfg(tb_open_cfg), .op_ww(tb_open_wwait), .op_src(tb_open_src),
    .op_trd(tb_open_trd), .op_pkt(tb_open_pkt),
    .lk_line(r_line), .dec_en(tb_dec),
    .hit(tb_hit), .hit_last(tb_last), .hit_cfg(tb_cfg), .hit_ww(tb_ww),
    .hit_src(tb_src), .hit_trd(tb_trd), .hit_pkt(tb_pkt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      r_line <= '0; r_id <= '0; r_inst <= 1'b0; r_way <= '0;
      r_own_id <= '0; r_own_inst <= 1'b0; r_cnt <= '0; r_ptr <= '0;
      r_prev <= '0; r_cur <= '0; r_nown_id <= '0; r_nown_inst <= 1'b0; r_nptr <= '0;
      r_found <= 1'b0; r_fix <= 1'b0; r_fix_idx <= '0; r_fix_next <= '0;
      r_free_need <= 1'b0; r_free_idx <= '0;
      free_head <= '0; free_valid <= 1'b0;
      r_w_src <= '0; r_w_trd <= '0; r_w_pkt <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (req_valid) begin
          r_line <= req_line; r_id <= req_id; r_inst <= req_inst; r_way <= req_way;
          r_own_id <= snap_own_id; r_own_inst <= snap_own_inst;
          r_cnt <= snap_cnt; r_ptr <= snap_ptr;
          r_found <= 1'b0; r_fix <= 1'b0; r_free_need <= 1'b0;
          st <= S_REQ;
        end
        S_REQ: if (heap_grant) st <= S_LOCK;
        S_LOCK: begin
          r_nown_id <= r_own_id; r_nown_inst <= r_own_inst; r_nptr <= r_ptr;
          r_free_idx <= r_ptr;
          if (own_hit) begin
            r_found <= 1'b1;
            if (multi) begin
              r_nown_id <= h_id; r_nown_inst <= h_inst;
              r_nptr <= h_last ? r_ptr : h_next;
              r_free_need <= 1'b1;
            end
            st <= S_COMMIT;
          end else if (multi && h_hit) begin
            r_found <= 1'b1;
            r_nptr <= h_last ? r_ptr : h_next;
            r_free_need <= 1'b1;
            st <= S_COMMIT;
          end else if (multi && !h_last) begin
            r_prev <= r_ptr; r_cur <= h_next;
            st <= S_SEARCH;
          end else begin
            st <= S_COMMIT;
          end
        end
        S_SEARCH: begin
          if (h_hit) begin
            r_found <= 1'b1; r_fix <= 1'b1;
            r_fix_idx <= r_prev; r_fix_next <= f_relink(r_prev, r_cur, h_next);
            r_free_need <= 1'b1; r_free_idx <= r_cur;
            st <= S_COMMIT;
          end else if (h_last) begin
            st <= S_COMMIT;
          end else begin
            r_prev <= r_cur; r_cur <= h_next;
          end
        end
        S_COMMIT: st <= r_free_need ? S_FREE : S_TBL;
        S_FREE: begin
          free_head <= r_free_idx; free_valid <= 1'b1;
          st <= S_TBL;
        end
        S_TBL: begin
          if (tb_hit && tb_last && tb_ww) begin
            r_w_src <= tb_src; r_w_trd <= tb_trd; r_w_pkt <= tb_pkt;
            st <= S_WRSP;
          end else begin
            st <= S_ACK;
          end
        end
        S_WRSP: st <= S_ACK;
        S_ACK:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready       = (st == S_IDLE);
  assign heap_req        = (st == S_REQ) || (st == S_LOCK) || (st == S_SEARCH) ||
                           (st == S_COMMIT) || (st == S_FREE);
  assign dir_wr          = (st == S_COMMIT) && r_found;
  assign dir_wr_line     = r_line;
  assign dir_wr_own_id   = r_nown_id;
  assign dir_wr_own_inst = r_nown_inst;
  assign dir_wr_ptr      = r_nptr;
  assign dir_wr_cnt      = r_cnt - CNT_W'(1);
  assign cfg_line_dec    = tb_dec && tb_last && tb_cfg;
  assign wr_rsp_valid    = (st == S_WRSP);
  assign wr_rsp_src      = r_w_src;
  assign wr_rsp_trd      = r_w_trd;
  assign wr_rsp_pkt      = r_w_pkt;
  assign ack_valid       = (st == S_ACK);
  assign ack_line        = r_line;
  assign ack_way         = r_way;
  assign ack_id          = r_id;
endmodule

// File: rtl/sharer_cleanup_engine_chk.sv
module sharer_cleanup_engine_chk #(
  parameter int HP_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            heap_req,
  input logic            heap_grant,
  input logic            dir_wr,
  input logic [HP_W-1:0] free_head,
  input logic            wr_rsp_valid,
  input logic            ack_valid,
  input logic            lock_wait,
  input logic            heap_wr_evt
);
  p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_wait && !heap_grant) |=> (!dir_wr && !heap_wr_evt));
  p_dir_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |-> (heap_grant && heap_req));
  p_heap_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    heap_wr_evt |-> (heap_grant && heap_req));
  p_free_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(free_head) |-> $past(heap_wr_evt));
  p_wrrsp_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rsp_valid |=> ack_valid);
  p_ack_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> (!ack_valid && req_ready));
endmodule

bind sharer_cleanup_engine sharer_cleanup_engine_chk #(.HP_W(HP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .heap_req(heap_req), .heap_grant(heap_grant), .dir_wr(dir_wr), .free_head(free_head),
  .wr_rsp_valid(wr_rsp_valid), .ack_valid(ack_valid),
  .lock_wait(lock_wait), .heap_wr_evt(heap_wr_evt)
);

// File: tb/sharer_cleanup_engine_bench.sv
module sharer_cleanup_engine_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_ready, req_inst = 0, snap_own_inst = 0;
  logic [7:0] req_line = 0;
  logic [3:0] req_id = 0, snap_own_id = 0, snap_cnt = 0;
  logic [1:0] req_way = 0;
  logic [2:0] snap_ptr = 0;
  logic heap_req, heap_grant = 0;
  logic dir_wr, dir_wr_own_inst, free_valid;
  logic [7:0] dir_wr_line;
  logic [3:0] dir_wr_own_id, dir_wr_cnt;
  logic [2:0] dir_wr_ptr, free_head;
  logic hp_ld = 0, hp_ld_inst = 0;
  logic [2:0] hp_ld_idx = 0, hp_ld_next = 0;
  logic [3:0] hp_ld_id = 0;
  logic tb_open = 0, tb_open_cfg = 0, tb_open_wwait = 0;
  logic [1:0] tb_open_idx = 0;
  logic [7:0] tb_open_line = 0;
  logic [3:0] tb_open_cnt = 0, tb_open_src = 0, tb_open_pkt = 0;
  logic [2:0] tb_open_trd = 0;
  logic cfg_line_dec, wr_rsp_valid, ack_valid;
  logic [3:0] wr_rsp_src, wr_rsp_pkt, ack_id;
  logic [2:0] wr_rsp_trd;
  logic [7:0] ack_line;
  logic [1:0] ack_way;

  sharer_cleanup_engine u_sharer_cleanup_engine (.*);

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit stall_hold = 0, g_slow = 0;

  // bench model: per line slot, owner, count and ordered heap indices
  int o_id[4], o_inst[4], cnt[4], llen[4];
  int lst[4][4];
  int hid[8], hinst[8];
  bit pused[8];
  bit tv[4], tcfg[4], tww[4];
  int tc[4], tsrc[4], ttrd[4], tpkt[4];

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int line_of(int l); return 8'h10 + l; endfunction

  function automatic int pool_free();
    int n = 0;
    for (int i = 0; i < 8; i++) if (!pused[i]) n++;
    return n;
  endfunction

  function automatic int alloc();
    for (int i = 0; i < 8; i++) if (!pused[i]) begin pused[i] = 1; return i; end
    return 0;
  endfunction

  // lock arbiter model: grant only while requested, held until released
  always @(negedge clk) begin
    cyc++;
    if (!heap_req) heap_grant = 0;
    else if (!heap_grant && !stall_hold && (!g_slow || ($urandom % 3 == 0))) heap_grant = 1;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic build(int l, int n, bit open_tb);
    int base;
    for (int k = 0; k < llen[l]; k++) pused[lst[l][k]] = 0;
    base = $urandom % 12;
    o_id[l] = base; o_inst[l] = $urandom % 2; cnt[l] = n; llen[l] = n - 1;
    for (int k = 0; k < n - 1; k++) begin
      lst[l][k] = alloc();
      hid[lst[l][k]] = base + k + 1; hinst[lst[l][k]] = $urandom % 2;
    end
    for (int k = 0; k < n - 1; k++) begin
      @(negedge clk);
      hp_ld = 1; hp_ld_idx = 3'(lst[l][k]); hp_ld_id = 4'(hid[lst[l][k]]);
      hp_ld_inst = hinst[lst[l][k]][0];
      hp_ld_next = 3'((k == n - 2) ? lst[l][k] : lst[l][k+1]);
    end
    if (open_tb) begin
      tv[l] = 1; tc[l] = 1 + $urandom % (n + 1); tcfg[l] = $urandom % 2; tww[l] = $urandom % 2;
      tsrc[l] = $urandom % 16; ttrd[l] = $urandom % 8; tpkt[l] = $urandom % 16;
      @(negedge clk);
      hp_ld = 0;
      tb_open = 1; tb_open_idx = 2'(l); tb_open_line = 8'(line_of(l)); tb_open_cnt = 4'(tc[l]);
      tb_open_cfg = tcfg[l]; tb_open_wwait = tww[l]; tb_open_src = 4'(tsrc[l]);
      tb_open_trd = 3'(ttrd[l]); tb_open_pkt = 4'(tpkt[l]);
    end
    @(negedge clk);
    hp_ld = 0; tb_open = 0;
  endtask

  // pos: 0 = owner slot, k>=1 = heap position k-1, -1 = owner id with flipped flag
  task automatic clean(int l, int pos, int stall);
    int tid, tins, way, e_found, e_free, e_cnt, e_oid, e_oins, e_ptr, e_cfg, e_wr;
    int n_dw, n_cfg, n_wr, got_ack, wr_cyc, ack_cyc, d_oid, d_oins, d_ptr, d_cnt, d_line;
    int w_src, w_trd, w_pkt, a_line, a_way, a_id, fh0, fv0;
    way = $urandom % 4;
    if (pos == 0) begin tid = o_id[l]; tins = o_inst[l]; end
    else if (pos > 0) begin tid = hid[lst[l][pos-1]]; tins = hinst[lst[l][pos-1]]; end
    else begin tid = o_id[l]; tins = 1 - o_inst[l]; end
    // expected outcome from the requirements
    e_found = (pos >= 0 && cnt[l] > 0); e_free = -1;
    e_oid = o_id[l]; e_oins = o_inst[l]; e_cnt = cnt[l] - 1; e_ptr = -1;
    if (e_found) begin
      if (pos == 0 && llen[l] > 0) begin e_oid = hid[lst[l][0]]; e_oins = hinst[lst[l][0]]; end
      if (llen[l] > 0) begin
        int j;
        j = (pos <= 1) ? 0 : pos - 1;
        e_free = lst[l][j];
        for (int k = j; k < llen[l] - 1; k++) lst[l][k] = lst[l][k+1];
        llen[l]--; pused[e_free] = 0;
      end
      if (llen[l] > 0) e_ptr = lst[l][0];
    end
    e_cfg = 0; e_wr = 0;
    if (tv[l]) begin
      tc[l]--;
      if (tc[l] == 0) begin tv[l] = 0; e_cfg = tcfg[l]; e_wr = tww[l]; end
    end
    fh0 = free_head; fv0 = free_valid;
    @(negedge clk);
    chk("R1 ready when idle", req_ready, 1);
    req_valid = 1; req_line = 8'(line_of(l)); req_id = 4'(tid); req_inst = tins[0]; req_way = 2'(way);
    snap_own_id = 4'(o_id[l]); snap_own_inst = o_inst[l][0]; snap_cnt = 4'(cnt[l]);
    snap_ptr = 3'((llen[l] + (e_free >= 0 ? 1 : 0) > 0) ? (e_found && pos <= 1 && e_free >= 0 ? e_free : (llen[l] > 0 ? lst[l][0] : 0)) : 0);
    @(negedge clk);
    req_valid = 0;
    chk("R1 busy after accept", req_ready, 0);
    n_dw = 0; n_cfg = 0; n_wr = 0; got_ack = 0; wr_cyc = -5; ack_cyc = 0;
    d_oid = 0; d_oins = 0; d_ptr = 0; d_cnt = 0; d_line = 0; w_src = 0; w_trd = 0; w_pkt = 0;
    a_line = 0; a_way = 0; a_id = 0;
    for (int c = 0; c < 300 && !got_ack; c++) begin
      if (c < stall) begin
        chk("R8 lock requested while stalled", heap_req, 1);
        chk("R8 no directory write while stalled", dir_wr, 0);
        chk("R8 free list untouched while stalled", free_head, fh0);
        if (c == stall - 1) stall_hold = 0;
      end
      if (dir_wr) begin
        n_dw++; d_oid = dir_wr_own_id; d_oins = dir_wr_own_inst; d_ptr = dir_wr_ptr;
        d_cnt = dir_wr_cnt; d_line = dir_wr_line;
      end
      if (cfg_line_dec) n_cfg++;
      if (wr_rsp_valid) begin n_wr++; wr_cyc = c; w_src = wr_rsp_src; w_trd = wr_rsp_trd; w_pkt = wr_rsp_pkt; end
      if (ack_valid) begin got_ack = 1; ack_cyc = c; a_line = ack_line; a_way = ack_way; a_id = ack_id; end
      if (!got_ack) @(negedge clk);
    end
    chk("R12 ack seen", got_ack, 1);
    chk("R12 ack line", a_line, line_of(l));
    chk("R12 ack way", a_way, way);
    chk("R12 ack id", a_id, tid);
    chk(pos < 0 ? "R2 R6 no update on flag mismatch" : "R8 single directory write", n_dw, e_found);
    if (e_found && n_dw == 1) begin
      chk("R3 R4 R5 count minus one", d_cnt, e_cnt);
      chk("R3 R4 R5 line", d_line, line_of(l));
      if (e_cnt >= 1) begin
        chk(pos == 0 ? "R3 promoted owner id" : "R4 R5 owner kept", d_oid, e_oid);
        chk(pos == 0 ? "R3 promoted owner flag" : "R4 R5 owner flag kept", d_oins, e_oins);
      end
      if (e_ptr >= 0) chk(pos <= 1 ? "R3 R4 pointer to successor" : "R5 pointer unchanged", d_ptr, e_ptr);
    end
    if (e_free >= 0) begin
      chk("R7 freed entry heads free list", free_head, e_free);
      chk("R7 free list valid", free_valid, 1);
    end else begin
      chk("R6 free list unchanged", free_head, fh0);
      chk("R6 free flag unchanged", free_valid, fv0);
    end
    chk(tv[l] || e_cfg ? "R10 config line decrement" : "R9 R10 no config decrement", n_cfg, e_cfg);
    chk("R11 write response count", n_wr, e_wr);
    if (e_wr && n_wr == 1) begin
      chk("R11 write response one cycle before ack", ack_cyc - wr_cyc, 1);
      chk("R11 saved source", w_src, tsrc[l]);
      chk("R11 saved transaction", w_trd, ttrd[l]);
      chk("R11 saved packet", w_pkt, tpkt[l]);
    end
    if (e_found) begin cnt[l] = e_cnt; o_id[l] = e_oid; o_inst[l] = e_oins; end
    @(negedge clk);
    chk("R1 ready after ack", req_ready, 1);
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 4; i++) begin cnt[i] = 0; llen[i] = 0; tv[i] = 0; end
    for (int i = 0; i < 8; i++) pused[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset ready", req_ready, 1);
    chk("R8 reset no lock request", heap_req, 0);
    chk("R7 reset free list empty", free_valid, 0);
    chk("R12 reset no ack", ack_valid, 0);
    chk("R8 reset no directory write", dir_wr, 0);

    // directed: four sharers on slot 0, table entry expecting two responses
    build(0, 4, 0);
    tv[0] = 1; tc[0] = 2; tcfg[0] = 1; tww[0] = 1; tsrc[0] = 9; ttrd[0] = 5; tpkt[0] = 12;
    @(negedge clk);
    tb_open = 1; tb_open_idx = 0; tb_open_line = 8'h10; tb_open_cnt = 2; tb_open_cfg = 1;
    tb_open_wwait = 1; tb_open_src = 9; tb_open_trd = 5; tb_open_pkt = 12;
    @(negedge clk); tb_open = 0;
    clean(0, 2, 0);     // R5 middle of list
    clean(0, 2, 0);     // R5 last of list, predecessor self-terminates; R10 R11 entry clears
    clean(0, -1, 0);    // R2 R6 R9 flag mismatch, no table entry left
    stall_hold = 1;
    clean(0, 0, 6);     // R3 R8 owner match with head promotion after a stall
    clean(0, 0, 0);     // R3 last sharer leaves, count reaches zero
    build(1, 3, 1);
    clean(1, 1, 0);     // R4 head match
    clean(1, 1, 0);     // R4 new head is last

    // constrained random
    g_slow = 1;
    for (int it = 0; it < 80; it++) begin
      int l, n, p;
      l = $urandom % 4;
      if (cnt[l] == 0 || $urandom % 6 == 0) begin
        n = 1 + $urandom % 4;
        if (n - 1 > pool_free() + llen[l]) n = pool_free() + llen[l] + 1;
        build(l, n, ($urandom % 3) != 0);
      end
      p = ($urandom % 5 == 0) ? -1 : $urandom % cnt[l];
      clean(l, p, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule